// File: doc/BRIEF.md
# PCI configuration cycle address generator

This block serves one host request at a time for PCI configuration space. A request names a bus, a device, a function, a register offset, an access size of 1, 2 or 4 bytes, and a direction. The block checks that the request can be served. It then produces two things: a value for an outbound window register, which tells the bridge whether the cycle leaves as a Type 0 or a Type 1 configuration transaction, and a word-aligned address on a 32-bit memory-side port.

On a Type 0 cycle (bus 0), the device is selected by one bit, at position device + 16. The window covers address bits from `SPLIT_BIT` upward. If the selection bit lands in that field, it travels in the window value; otherwise it travels in the address. Any nonzero bus produces a Type 1 cycle, which packs bus, device, function and register in the usual Type 1 layout.

Reads return only the addressed bytes. Sub-word writes do a read, merge the new bytes into the word, and write the word back. Illegal requests and memory-side faults end the request with an error flag on a one-cycle completion pulse.

Top module: `pci_cfg_addr_gen`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, and `done`, `mem_valid` and `win_we` are 0.
- R2: A request whose size is not 1, 2 or 4 completes with `done_err` = 1. It makes no memory access and no window write.
- R3: A request on bus 0 with device 16 or above completes with an error.
- R4: While `cardbus_mode` is 1, any request to a device other than 0 completes with an error, on any bus. Device 0 is still served.
- R5: For a Type 0 cycle, the selection bit is 1 << (device+16).
  - `win_data` = `WIN_T0` OR (the selection bit masked to bits `SPLIT_BIT`..31).
  - `mem_addr` = `CFG_BASE` OR (the selection bit masked to bits below `SPLIT_BIT`) OR (function << 8) OR (offset AND 0xFC).
- R6: For a Type 1 cycle (bus not 0):
  - `win_data` = `WIN_T1`.
  - `mem_addr` = `CFG_BASE` OR (bus << 16) OR (device << 11) OR (function << 8) OR (offset AND 0xFC).
- R7: The read result is the word shifted right by 8 × (offset mod 4), then kept to its low 8, 16 or 32 bits for sizes 1, 2 and 4. The upper bits are zero.
- R8: A 1- or 2-byte write first reads the aligned word. It then writes back that word with lanes replaced. The lanes are mask 0xFF (size 1) or 0xFFFF (size 2) shifted left by 8 × (offset mod 4) and cut to 32 bits; they take the new data shifted by the same amount. Other bits are kept.
- R9: A 4-byte write makes exactly one memory write of `req_wdata`, unshifted, and no read.
- R10: A `mem_fault` on any accepted memory beat ends the request in the next cycle with `done_err` = 1. No later memory beat happens for that request.
- R11: Only one request is in flight. `req_ready` is 0 from the cycle after acceptance until completion. `done` is a one-cycle pulse, and `req_ready` returns in the cycle after it.
- R12: A served request pulses `win_we` exactly once, in the cycle before its first memory beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cardbus_mode | input | 1 | Only device 0 is reachable when set |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken on valid and ready |
| req_write | input | 1 | 1 for write, 0 for read |
| req_bus | input | 8 | Bus number |
| req_dev | input | 5 | Device number |
| req_func | input | 3 | Function number |
| req_off | input | 8 | Register byte offset |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Request failed, valid with done |
| done_rdata | output | 32 | Read result, valid with done |
| win_we | output | 1 | Window register write strobe |
| win_data | output | 32 | Window register value |
| mem_valid | output | 1 | Memory beat request |
| mem_write | output | 1 | Memory beat direction |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write word |
| mem_ready | input | 1 | Memory beat accepted |
| mem_rdata | input | 32 | Memory read word |
| mem_fault | input | 1 | Memory beat faulted, valid with ready |

## Verification
The bench builds the block with its defaults: `CFG_BASE` = 0x0C00_0000, `SPLIT_BIT` = 26, `WIN_T0` = 2 and `WIN_T1` = 3. With these values, devices 0 to 9 put their selection bit in the address, and devices 10 to 15 put it in the window value. Both sides of the split are therefore exercised, alongside the device-16 boundary. The bench's memory model can fault reads and writes separately. This covers a fault on the read half of a merge, which must suppress the write-back.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

    localparam int BUS_W  = 8;
    localparam int DEV_W  = 5;
    localparam int FUNC_W = 3;
    localparam int OFF_W  = 8;
    localparam int SIZE_W = 3;
    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;
    localparam int T0_BIT_BASE = 16;
    localparam int T0_DEV_LIMIT = WORD_W - T0_BIT_BASE;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEC,
        ST_RD,
        ST_WR,
        ST_FIN
    } pcfg_state_e;

    typedef struct packed {
        logic              write;
        logic [BUS_W-1:0]  bus;
        logic [DEV_W-1:0]  dev;
        logic [FUNC_W-1:0] func;
        logic [OFF_W-1:0]  off;
        logic [SIZE_W-1:0] size;
        logic [WORD_W-1:0] wdata;
    } pcfg_req_t;

    function automatic logic size_legal(input logic [SIZE_W-1:0] sz);
        return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
    endfunction

    function automatic logic [LANES-1:0] lane_enables(input logic [SIZE_W-1:0] sz,
                                                      input logic [1:0] lane);
        logic [LANES-1:0] be;
        case (sz)
            3'd1:    be = 4'b0001 << lane;
            3'd2:    be = 4'b0011 << lane;
            default: be = 4'b1111;
        endcase
        return be;
    endfunction

endpackage

// File: rtl/pcfg_route.sv
module pcfg_route
    import pcfg_pkg::*;
#(
    parameter logic [WORD_W-1:0] CFG_BASE  = 32'h0C00_0000,
    parameter int                SPLIT_BIT = 26,
    parameter logic [WORD_W-1:0] WIN_T0    = 32'h0000_0002,
    parameter logic [WORD_W-1:0] WIN_T1    = 32'h0000_0003
) (
    input  pcfg_req_t         req,
    input  logic              cardbus_mode,
    output logic              err,
    output logic [WORD_W-1:0] win_val,
    output logic [WORD_W-1:0] addr
);
    localparam logic [WORD_W-1:0] WIN_MASK = ~((WORD_W'(1) << SPLIT_BIT) - WORD_W'(1));

    logic              type0;
    logic [5:0]        sel_pos;
    logic [WORD_W-1:0] sel_bit;
    logic [WORD_W-1:0] low_part;

    always_comb begin
        type0    = (req.bus == '0);
        sel_pos  = 6'(req.dev) + 6'(T0_BIT_BASE);
        sel_bit  = WORD_W'(1) << sel_pos;
        low_part = (WORD_W'(req.func) << 8) | WORD_W'(req.off & 8'hFC);

        err = !size_legal(req.size)
            || (cardbus_mode && (req.dev != '0))
            || (type0 && (32'(req.dev) >= T0_DEV_LIMIT));

        if (type0) begin
            win_val = WIN_T0 | (sel_bit & WIN_MASK);
            addr    = CFG_BASE | (sel_bit & ~WIN_MASK) | low_part;
        end else begin
            win_val = WIN_T1;
            addr    = CFG_BASE | (WORD_W'(req.bus) << 16)
                    | (WORD_W'(req.dev) << 11) | low_part;
        end
    end
endmodule

// File: rtl/pcfg_lane.sv
module pcfg_lane
    import pcfg_pkg::*;
(
    input  logic [SIZE_W-1:0] size,
    input  logic [1:0]        lane,
    input  logic [WORD_W-1:0] old_word,
    input  logic [WORD_W-1:0] new_data,
    output logic [WORD_W-1:0] rd_val,
    output logic [WORD_W-1:0] merged
);
    logic [WORD_W-1:0] down;
    logic [WORD_W-1:0] up;
    logic [LANES-1:0]  be;

    always_comb begin
        down = old_word >> {lane, 3'b000};
        case (size)
            3'd1:    rd_val = {24'd0, down[7:0]};
            3'd2:    rd_val = {16'd0, down[15:0]};
            default: rd_val = down;
        endcase
        up = (size == 3'd4) ? new_data : (new_data << {lane, 3'b000});
        be = lane_enables(size, lane);
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign merged[8*i +: 8] = be[i] ? up[8*i +: 8] : old_word[8*i +: 8];
    end
endmodule

// File: rtl/pcfg_seq.sv
module pcfg_seq
    import pcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  pcfg_req_t         req_in,
    output logic              req_ready,
    output pcfg_req_t         req_q,
    input  logic              route_err,
    input  logic [WORD_W-1:0] lane_rd,
    input  logic [WORD_W-1:0] lane_merged,
    output logic              win_we,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic              mem_fault,
    output logic              done,
    output logic              done_err,
    output logic [WORD_W-1:0] done_rdata
);
    pcfg_state_e       state;
    logic [WORD_W-1:0] wbuf;
    logic              full_write;

    assign full_write = req_q.write && (req_q.size == 3'd4);
    assign req_ready  = (state == ST_IDLE);
    assign win_we     = (state == ST_DEC) && !route_err;
    assign mem_valid  = (state == ST_RD) || (state == ST_WR);
    assign mem_write  = (state == ST_WR);
    assign mem_wdata  = wbuf;
    assign done       = (state == ST_FIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            req_q      <= '0;
            wbuf       <= '0;
            done_err   <= 1'b0;
            done_rdata <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    req_q      <= req_in;
                    done_err   <= 1'b0;
                    done_rdata <= '0;
                    state      <= ST_DEC;
                end
                ST_DEC: if (route_err) begin
                    done_err <= 1'b1;
                    state    <= ST_FIN;
                end else if (full_write) begin
                    wbuf  <= req_q.wdata;
                    state <= ST_WR;
                end else begin
                    state <= ST_RD;
                end
                ST_RD: if (mem_ready) begin
                    if (mem_fault) begin
                        done_err <= 1'b1;
                        state    <= ST_FIN;
                    end else if (req_q.write) begin
                        wbuf  <= lane_merged;
                        state <= ST_WR;
                    end else begin
                        done_rdata <= lane_rd;
                        state      <= ST_FIN;
                    end
                end
                ST_WR: if (mem_ready) begin
                    done_err <= mem_fault;
                    state    <= ST_FIN;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pci_cfg_addr_gen.sv
module pci_cfg_addr_gen
    import pcfg_pkg::*;
#(
    parameter logic [31:0] CFG_BASE  = 32'h0C00_0000,
    parameter int          SPLIT_BIT = 26,
    parameter logic [31:0] WIN_T0    = 32'h0000_0002,
    parameter logic [31:0] WIN_T1    = 32'h0000_0003
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cardbus_mode,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic [7:0]  req_bus,
    input  logic [4:0]  req_dev,
    input  logic [2:0]  req_func,
    input  logic [7:0]  req_off,
    input  logic [2:0]  req_size,
    input  logic [31:0] req_wdata,
    output logic        done,
    output logic        done_err,
    output logic [31:0] done_rdata,
    output logic        win_we,
    output logic [31:0] win_data,
    output logic        mem_valid,
    output logic        mem_write,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ready,
    input  logic [31:0] mem_rdata,
    input  logic        mem_fault
);
    pcfg_req_t         req_in;
    pcfg_req_t         req_q;
    logic              route_err;
    logic [WORD_W-1:0] lane_rd;
    logic [WORD_W-1:0] lane_merged;

    assign req_in = '{write: req_write, bus: req_bus, dev: req_dev, func: req_func,
                      off: req_off, size: req_size, wdata: req_wdata};

    pcfg_seq u_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_in(req_in), .req_ready(req_ready), .req_q(req_q),
        .route_err(route_err), .lane_rd(lane_rd), .lane_merged(lane_merged),
        .win_we(win_we), .mem_valid(mem_valid), .mem_write(mem_write),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_fault(mem_fault),
        .done(done), .done_err(done_err), .done_rdata(done_rdata)
    );

    pcfg_route #(
        .CFG_BASE(CFG_BASE), .SPLIT_BIT(SPLIT_BIT), .WIN_T0(WIN_T0), .WIN_T1(WIN_T1)
    ) u_route (
        .req(req_q), .cardbus_mode(cardbus_mode),
        .err(route_err), .win_val(win_data), .addr(mem_addr)
    );

    pcfg_lane u_lane (
        .size(req_q.size), .lane(req_q.off[1:0]), .old_word(mem_rdata),
        .new_data(req_q.wdata), .rd_val(lane_rd), .merged(lane_merged)
    );
endmodule

// File: rtl/pcfg_checker.sv
module pcfg_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        done,
    input logic        done_err,
    input logic        win_we,
    input logic        mem_valid,
    input logic        mem_write,
    input logic [31:0] mem_addr,
    input logic        mem_ready,
    input logic        mem_fault
);
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && !done && !mem_valid && !win_we));

    p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && req_ready));

    p_idle_no_mem_r11: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_valid);

    p_win_then_mem_r12: assert property (@(posedge clk) disable iff (rst)
        win_we |-> !mem_valid ##1 mem_valid);

    p_beat_held_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));

    p_fault_ends_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready && mem_fault) |=> (done && done_err && !mem_valid));

    p_write_last_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready && mem_write) |=> done);
endmodule

bind pci_cfg_addr_gen pcfg_checker u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .done(done), .done_err(done_err), .win_we(win_we), .mem_valid(mem_valid),
    .mem_write(mem_write), .mem_addr(mem_addr), .mem_ready(mem_ready),
    .mem_fault(mem_fault)
);

// File: tb/pci_cfg_addr_gen_tb.sv
module pci_cfg_addr_gen_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cardbus_mode = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [4:0]  req_dev = '0;
    logic [2:0]  req_func = '0;
    logic [7:0]  req_off = '0;
    logic [2:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        done, done_err;
    logic [31:0] done_rdata;
    logic        win_we;
    logic [31:0] win_data;
    logic        mem_valid, mem_write;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ready;
    logic [31:0] mem_rdata;
    logic        mem_fault;

    logic [31:0] mem_word = 32'hA1B2_C3D4;
    logic        fault_rd = 1'b0;
    logic        fault_wr = 1'b0;
    logic        clr_mon = 1'b0;

    int          rd_cnt, wr_cnt, win_cnt;
    logic        order_bad;
    logic [31:0] rd_addr, wr_addr, wr_data, win_last;

    int checks = 0;
    int errors = 0;

    logic        got_err, saw_done, busy_seen, done_after, ready_after;
    logic [31:0] got_rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_ready = mem_valid;
    assign mem_rdata = mem_word;
    assign mem_fault = mem_valid && ((fault_rd && !mem_write) || (fault_wr && mem_write));

    pci_cfg_addr_gen u_dut (
        .clk(clk), .rst(rst), .cardbus_mode(cardbus_mode),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func), .req_off(req_off),
        .req_size(req_size), .req_wdata(req_wdata),
        .done(done), .done_err(done_err), .done_rdata(done_rdata),
        .win_we(win_we), .win_data(win_data),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .mem_fault(mem_fault)
    );

    always @(posedge clk) begin
        if (clr_mon) begin
            rd_cnt <= 0; wr_cnt <= 0; win_cnt <= 0; order_bad <= 1'b0;
            rd_addr <= '0; wr_addr <= '0; wr_data <= '0; win_last <= '0;
        end else begin
            if (mem_valid && mem_ready) begin
                if (mem_write) begin
                    wr_cnt <= wr_cnt + 1; wr_addr <= mem_addr; wr_data <= mem_wdata;
                end else begin
                    rd_cnt <= rd_cnt + 1; rd_addr <= mem_addr;
                end
                if (win_cnt == 0) order_bad <= 1'b1;
            end
            if (win_we) begin
                win_cnt <= win_cnt + 1; win_last <= win_data;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] got,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_req(input bit wr, input logic [7:0] bus, input logic [4:0] dev,
                          input logic [2:0] fn, input logic [7:0] off,
                          input logic [2:0] sz, input logic [31:0] wd);
        int n;
        @(negedge clk);
        req_write = wr; req_bus = bus; req_dev = dev; req_func = fn;
        req_off = off; req_size = sz; req_wdata = wd;
        req_valid = 1'b1; clr_mon = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; clr_mon = 1'b0;
        busy_seen = !req_ready;
        n = 0;
        while (!done && n < 50) begin
            @(negedge clk);
            n++;
        end
        saw_done = done; got_err = done_err; got_rd = done_rdata;
        @(negedge clk);
        done_after = done; ready_after = req_ready;
    endtask

    task automatic t_reset;
        chk(req_ready === 1'b1, "R1 ready", 32'(req_ready), 32'd1);
        chk(done === 1'b0 && mem_valid === 1'b0 && win_we === 1'b0, "R1 quiet outputs",
            {29'd0, done, mem_valid, win_we}, 32'd0);
    endtask

    task automatic t_type0_read;
        do_req(1'b0, 8'd0, 5'd3, 3'd2, 8'h14, 3'd4, '0);
        chk(saw_done && !got_err, "R5 dev3 served", 32'(got_err), 32'd0);
        chk(win_last == 32'h0000_0002, "R5 dev3 window", win_last, 32'h0000_0002);
        chk(rd_addr == 32'h0C08_0214, "R5 dev3 address", rd_addr, 32'h0C08_0214);
        chk(got_rd == 32'hA1B2_C3D4, "R7 size4 read", got_rd, 32'hA1B2_C3D4);
        chk(win_cnt == 1 && !order_bad, "R12 window once before memory",
            32'(win_cnt), 32'd1);
        do_req(1'b0, 8'd0, 5'd12, 3'd1, 8'h3E, 3'd1, '0);
        chk(win_last == 32'h1000_0002, "R5 dev12 window bit", win_last, 32'h1000_0002);
        chk(rd_addr == 32'h0C00_013C, "R5 dev12 address", rd_addr, 32'h0C00_013C);
        chk(got_rd == 32'h0000_00B2, "R7 byte lane 2", got_rd, 32'h0000_00B2);
        do_req(1'b0, 8'd0, 5'd9, 3'd0, 8'h09, 3'd2, '0);
        chk(win_last == 32'h0000_0002, "R5 dev9 window", win_last, 32'h0000_0002);
        chk(rd_addr == 32'h0E00_0008, "R5 dev9 address", rd_addr, 32'h0E00_0008);
        chk(got_rd == 32'h0000_B2C3, "R7 half lane 1", got_rd, 32'h0000_B2C3);
    endtask

    task automatic t_type1;
        do_req(1'b0, 8'd1, 5'd16, 3'd0, 8'h00, 3'd4, '0);
        chk(saw_done && !got_err, "R6 dev16 on bus1 served", 32'(got_err), 32'd0);
        chk(win_last == 32'h0000_0003, "R6 window", win_last, 32'h0000_0003);
        chk(rd_addr == 32'h0C01_8000, "R6 address", rd_addr, 32'h0C01_8000);
    endtask

    task automatic t_partial_write;
        do_req(1'b1, 8'd5, 5'd7, 3'd3, 8'h42, 3'd2, 32'h0000_1234);
        chk(rd_cnt == 1 && wr_cnt == 1, "R8 read then write", 32'(rd_cnt + wr_cnt), 32'd2);
        chk(rd_addr == 32'h0C05_3B40 && wr_addr == 32'h0C05_3B40, "R6 write address",
            wr_addr, 32'h0C05_3B40);
        chk(wr_data == 32'h1234_C3D4, "R8 half merge", wr_data, 32'h1234_C3D4);
        do_req(1'b1, 8'd0, 5'd0, 3'd0, 8'h07, 3'd1, 32'h0000_00EE);
        chk(wr_addr == 32'h0C01_0004, "R5 dev0 address", wr_addr, 32'h0C01_0004);
        chk(wr_data == 32'hEEB2_C3D4, "R8 byte merge lane 3", wr_data, 32'hEEB2_C3D4);
        do_req(1'b1, 8'd0, 5'd2, 3'd0, 8'h0B, 3'd2, 32'h0000_5566);
        chk(wr_data == 32'h66B2_C3D4, "R8 half at lane 3 cut", wr_data, 32'h66B2_C3D4);
    endtask

    task automatic t_full_write;
        do_req(1'b1, 8'd0, 5'd1, 3'd0, 8'h12, 3'd4, 32'hCAFE_F00D);
        chk(rd_cnt == 0 && wr_cnt == 1, "R9 single write no read",
            32'(rd_cnt * 16 + wr_cnt), 32'd1);
        chk(wr_data == 32'hCAFE_F00D, "R9 data unshifted", wr_data, 32'hCAFE_F00D);
        chk(wr_addr == 32'h0C02_0010, "R9 address", wr_addr, 32'h0C02_0010);
    endtask

    task automatic t_bad_size;
        do_req(1'b0, 8'd0, 5'd1, 3'd0, 8'h00, 3'd3, '0);
        chk(saw_done && got_err, "R2 size3 error", 32'(got_err), 32'd1);
        chk(rd_cnt == 0 && wr_cnt == 0 && win_cnt == 0, "R2 no access",
            32'(rd_cnt + wr_cnt + win_cnt), 32'd0);
        do_req(1'b1, 8'd0, 5'd1, 3'd0, 8'h00, 3'd0, 32'h1);
        chk(got_err && wr_cnt == 0 && win_cnt == 0, "R2 size0 write rejected",
            32'(wr_cnt + win_cnt), 32'd0);
    endtask

    task automatic t_dev_range;
        do_req(1'b0, 8'd0, 5'd16, 3'd0, 8'h00, 3'd4, '0);
        chk(saw_done && got_err && rd_cnt == 0, "R3 dev16 bus0 error", 32'(got_err), 32'd1);
        do_req(1'b0, 8'd0, 5'd15, 3'd0, 8'h00, 3'd4, '0);
        chk(!got_err && win_last == 32'h8000_0002, "R3 dev15 served", win_last,
            32'h8000_0002);
    endtask

    task automatic t_cardbus;
        cardbus_mode = 1'b1;
        do_req(1'b0, 8'd2, 5'd1, 3'd0, 8'h00, 3'd4, '0);
        chk(got_err && rd_cnt == 0, "R4 cardbus dev1 error", 32'(got_err), 32'd1);
        do_req(1'b0, 8'd0, 5'd0, 3'd0, 8'h04, 3'd4, '0);
        chk(!got_err && rd_addr == 32'h0C01_0004, "R4 cardbus dev0 served", rd_addr,
            32'h0C01_0004);
        cardbus_mode = 1'b0;
    endtask

    task automatic t_faults;
        fault_rd = 1'b1;
        do_req(1'b0, 8'd0, 5'd2, 3'd0, 8'h00, 3'd4, '0);
        chk(got_err && rd_cnt == 1, "R10 read fault", 32'(got_err), 32'd1);
        do_req(1'b1, 8'd0, 5'd2, 3'd0, 8'h01, 3'd1, 32'h77);
        chk(got_err && wr_cnt == 0, "R10 no write-back after fault", 32'(wr_cnt), 32'd0);
        fault_rd = 1'b0; fault_wr = 1'b1;
        do_req(1'b1, 8'd0, 5'd2, 3'd0, 8'h00, 3'd4, 32'h77);
        chk(got_err && wr_cnt == 1, "R10 write fault", 32'(got_err), 32'd1);
        fault_wr = 1'b0;
    endtask

    task automatic t_one_at_a_time;
        do_req(1'b0, 8'd3, 5'd4, 3'd1, 8'h20, 3'd4, '0);
        chk(busy_seen, "R11 busy after accept", 32'(busy_seen), 32'd1);
        chk(saw_done && !done_after && ready_after, "R11 done pulse and ready",
            {30'd0, done_after, ready_after}, 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_type0_read();
        t_type1();
        t_partial_write();
        t_full_write();
        t_bad_size();
        t_dev_range();
        t_cardbus();
        t_faults();
        t_one_at_a_time();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule